// File: doc/BRIEF.md
# Cascaded Reload Square-Wave Timer

This block produces a square wave by counting one of four clock enables through two cascaded down-counters. An 8-bit prescaler steps once per selected source tick. An 8-bit main counter steps once per prescaler underflow. Each main-counter underflow flips the pulse output, so the output changes level once every (n+1)·(m+1) source ticks. Here n is the prescaler setting and m is the main-counter setting. The counters reload themselves on underflow, so the wave keeps running with no software involvement.

Software reaches the block through a small register bus with four addresses: prescaler, main counter, mode and interrupt flags. Writing a counter address loads its reload value and its live count together. Reading it returns the live count. The mode register holds the operating field, the polarity bit, the run bit, the pin select for the complementary output and the source select. The polarity bit sets the level the output starts at and also the output edge that raises the edge interrupt. An inverted copy of the pulse is driven together with an output-enable that gives the pin over to the wave. Two sticky interrupt flags record main-counter underflows and the chosen output edges.

Top module: `sqwave_timer`

## Requirements
- R1: After reset, every register reads 0, `pulse_out`, `comp_oe`, `uf_strobe`, `irq_under` and `irq_edge` are 0, and `comp_out` is 1.
- R2: A write to address 0 (prescaler) or address 1 (main counter) sets that counter's reload value and live count in the same cycle. A read of the same address returns the live count, including while counting.
- R3: The prescaler decrements once per selected tick. The main counter decrements once per prescaler underflow. A counter at 0 reloads instead of decrementing. `pulse_out` inverts on every main-counter underflow, that is, once every (n+1)·(m+1) selected ticks.
- R4: Mode bits 6:5 pick which bit of `src_tick` is the count source. Ticks on the other three bits have no effect.
- R5: Counting happens only while mode bit 3 (run) is 1 and mode bits 1:0 equal 01. Otherwise both counts hold.
- R6: Every mode write loads `pulse_out` with the inverse of the written bit 2. Bit 2 = 0 starts the output high and bit 2 = 1 starts it low.
- R7: With mode bit 2 = 0, a rising toggle of `pulse_out` sets `irq_edge`. With bit 2 = 1, a falling toggle sets it. Toggles the other way do not.
- R8: A mode write whose bits 1:0 are 01 sets `irq_edge`. A mode write with any other field value does not.
- R9: Each main-counter underflow asserts `uf_strobe` for that one clock and sets `irq_under`.
- R10: Both flags stay set until cleared by a write to address 3, where bit 0 clears `irq_under` and bit 1 clears `irq_edge`. If a set and a clear arrive in the same cycle, the set wins. A read of address 3 returns {6'b0, `irq_edge`, `irq_under`}.
- R11: `comp_out` is always the inverse of `pulse_out`, and `comp_oe` follows mode bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| src_tick | input | 4 | Four count-source clock enables |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address (0 prescaler, 1 main counter, 2 mode, 3 flags) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| pulse_out | output | 1 | Square-wave output |
| comp_out | output | 1 | Inverted square wave |
| comp_oe | output | 1 | Pin select for the inverted wave |
| uf_strobe | output | 1 | One-clock main-counter underflow pulse |
| irq_under | output | 1 | Sticky underflow interrupt request |
| irq_edge | output | 1 | Sticky output-edge interrupt request |

## Verification
The assertions check the following on every cycle:
- counter writes land in the live count;
- each enabled step decrements by one;
- an underflow restores the reload value;
- the pulse inverts on an underflow and holds otherwise;
- the counts hold while stopped;
- both flags set on their events and clear on their strobe.

Some behaviour can only be shown by the bench scenarios, because it depends on counting across many cycles. This covers the full (n+1)·(m+1) period for several prescaler, counter, source and polarity mixes, and the edge flag firing only on the second half-period for each polarity. It also covers the rejection of unselected sources and the selective clearing of one flag while the other stays set.

// File: rtl/sqw_pkg.sv
package sqw_pkg;
    localparam int DW     = 8;
    localparam int AW     = 2;
    localparam int NSRC   = 4;
    localparam int SRC_W  = $clog2(NSRC);

    localparam logic [1:0] MODE_PULSE = 2'b01;

    typedef enum logic [AW-1:0] {
        RA_PRE  = 2'd0,
        RA_TMR  = 2'd1,
        RA_MODE = 2'd2,
        RA_FLAG = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic             rsv;
        logic [SRC_W-1:0] src;
        logic             pin_en;
        logic             run;
        logic             pol;
        logic [1:0]       mode;
    } mode_t;
endpackage

// File: rtl/sqw_downcnt.sv
module sqw_downcnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec_en,
    output logic [W-1:0] count,
    output logic         uf
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic [W-1:0] rld;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        uf   = 1'b0;
        if (load) begin
            st_d.cnt = load_val;
            st_d.rld = load_val;
        end else if (dec_en) begin
            if (st_q.cnt == '0) begin
                st_d.cnt = st_q.rld;
                uf       = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.cnt;

    // R2: a write lands in the live count
    p_write_through_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> count == $past(load_val));
    // R3: an enabled step above zero decrements by one
    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_en && !load && count != '0) |=> count == $past(count) - 1'b1);
    // R3: an underflow restores the reload value
    p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
        uf |=> count == st_q.rld);
endmodule

// File: rtl/sqw_regs.sv
module sqw_regs
    import sqw_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    wdata,
    input  logic [DW-1:0]    pre_cnt,
    input  logic [DW-1:0]    tmr_cnt,
    input  logic             tmr_uf,
    input  logic             edge_hit,
    output logic [DW-1:0]    rdata,
    output logic             pre_load,
    output logic             tmr_load,
    output logic             mode_wr,
    output logic             start_pol,
    output logic [SRC_W-1:0] src_sel,
    output logic             running,
    output logic             pol,
    output logic             pin_en,
    output logic             irq_under,
    output logic             irq_edge
);
    typedef struct packed {
        mode_t mode;
        logic  uf_flag;
        logic  edge_flag;
    } st_t;

    st_t       st_d, st_q;
    reg_addr_e ra;
    mode_t     wmode;
    logic      flag_wr;

    assign ra       = reg_addr_e'(addr);
    assign wmode    = mode_t'(wdata);
    assign pre_load = wr_en && ra == RA_PRE;
    assign tmr_load = wr_en && ra == RA_TMR;
    assign mode_wr  = wr_en && ra == RA_MODE;
    assign flag_wr  = wr_en && ra == RA_FLAG;

    always_comb begin
        st_d = st_q;
        if (mode_wr) st_d.mode = wmode;
        st_d.uf_flag   = (st_q.uf_flag & ~(flag_wr & wdata[0])) | tmr_uf;
        st_d.edge_flag = (st_q.edge_flag & ~(flag_wr & wdata[1])) | edge_hit
                       | (mode_wr && wmode.mode == MODE_PULSE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        unique case (ra)
            RA_PRE:  rdata = pre_cnt;
            RA_TMR:  rdata = tmr_cnt;
            RA_MODE: rdata = st_q.mode;
            default: rdata = {{(DW-2){1'b0}}, st_q.edge_flag, st_q.uf_flag};
        endcase
    end

    assign start_pol = wmode.pol;
    assign src_sel   = st_q.mode.src;
    assign running   = st_q.mode.run && st_q.mode.mode == MODE_PULSE;
    assign pol       = st_q.mode.pol;
    assign pin_en    = st_q.mode.pin_en;
    assign irq_under = st_q.uf_flag;
    assign irq_edge  = st_q.edge_flag;

    // R9: an underflow always leaves the flag set
    p_uf_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_uf |=> irq_under);
    // R10: a clear with no competing set empties the flag
    p_w1c_under_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_wr && wdata[0] && !tmr_uf) |=> !irq_under);
    // R10: flags do not drop without a clear
    p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_edge && !flag_wr) |=> irq_edge);
    // R8: entering pulse mode raises the edge flag
    p_mode_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && wdata[1:0] == MODE_PULSE) |=> irq_edge);
endmodule

// File: rtl/sqw_outstage.sv
module sqw_outstage (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_wr,
    input  logic start_pol,
    input  logic pol,
    input  logic toggle,
    input  logic pin_en,
    output logic pulse_out,
    output logic comp_out,
    output logic comp_oe,
    output logic edge_hit
);
    typedef struct packed {
        logic level;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        edge_hit = 1'b0;
        if (mode_wr) begin
            st_d.level = ~start_pol;
        end else if (toggle) begin
            st_d.level = ~st_q.level;
            edge_hit   = (st_q.level == pol);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pulse_out = st_q.level;
    assign comp_out  = ~st_q.level;
    assign comp_oe   = pin_en;

    // R3: an underflow inverts the wave
    p_toggle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (toggle && !mode_wr) |=> pulse_out != $past(pulse_out));
    // R3: without an underflow or mode write the wave holds
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!toggle && !mode_wr) |=> $stable(pulse_out));
    // R6: a mode write sets the starting level
    p_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr |=> pulse_out == !$past(start_pol));
endmodule

// File: rtl/sqwave_timer.sv
module sqwave_timer
    import sqw_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_tick,
    input  logic            wr_en,
    input  logic [AW-1:0]   addr,
    input  logic [DW-1:0]   wdata,
    output logic [DW-1:0]   rdata,
    output logic            pulse_out,
    output logic            comp_out,
    output logic            comp_oe,
    output logic            uf_strobe,
    output logic            irq_under,
    output logic            irq_edge
);
    logic             pre_load, tmr_load, mode_wr, start_pol;
    logic [SRC_W-1:0] src_sel;
    logic             running, pol, pin_en, edge_hit;
    logic             tick_sel, pre_dec, pre_uf, tmr_uf;
    logic [DW-1:0]    pre_cnt, tmr_cnt;

    assign tick_sel  = src_tick[src_sel];
    assign pre_dec   = tick_sel && running;
    assign uf_strobe = tmr_uf;

    sqw_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .pre_cnt(pre_cnt), .tmr_cnt(tmr_cnt), .tmr_uf(tmr_uf), .edge_hit(edge_hit),
        .rdata(rdata), .pre_load(pre_load), .tmr_load(tmr_load), .mode_wr(mode_wr),
        .start_pol(start_pol), .src_sel(src_sel), .running(running), .pol(pol),
        .pin_en(pin_en), .irq_under(irq_under), .irq_edge(irq_edge)
    );

    sqw_downcnt #(.W(DW)) u_pre (
        .clk(clk), .rst_n(rst_n), .load(pre_load), .load_val(wdata),
        .dec_en(pre_dec), .count(pre_cnt), .uf(pre_uf)
    );

    sqw_downcnt #(.W(DW)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(wdata),
        .dec_en(pre_uf), .count(tmr_cnt), .uf(tmr_uf)
    );

    sqw_outstage u_out (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .start_pol(start_pol),
        .pol(pol), .toggle(tmr_uf), .pin_en(pin_en), .pulse_out(pulse_out),
        .comp_out(comp_out), .comp_oe(comp_oe), .edge_hit(edge_hit)
    );

    // R5: stopped counters hold unless written
    p_stop_pre_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !pre_load) |=> $stable(pre_cnt));
    p_stop_tmr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !tmr_load) |=> $stable(tmr_cnt));
    // R3: the main counter only moves on a prescaler underflow
    p_cascade_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!pre_uf && !tmr_load) |=> $stable(tmr_cnt));
endmodule

// File: tb/sqwave_timer_bench.sv
`timescale 1ns/1ps
module sqwave_timer_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] src_tick = '0;
    logic       wr_en = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       pulse_out, comp_out, comp_oe, uf_strobe, irq_under, irq_edge;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #2 clk = ~clk;

    sqwave_timer u_sqwave_timer (
        .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pulse_out(pulse_out), .comp_out(comp_out),
        .comp_oe(comp_oe), .uf_strobe(uf_strobe), .irq_under(irq_under),
        .irq_edge(irq_edge)
    );

    typedef struct packed {
        logic [7:0] n;
        logic [7:0] m;
        logic [1:0] src;
        logic       pol;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{8'd2, 8'd3, 2'd0, 1'b0},
        '{8'd0, 8'd4, 2'd1, 1'b1},
        '{8'd5, 8'd0, 2'd2, 1'b0},
        '{8'd3, 8'd2, 2'd3, 1'b1},
        '{8'd0, 8'd0, 2'd0, 1'b1}
    };

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] mk_mode(logic [1:0] src, logic pin, logic run,
                                           logic pol, logic [1:0] fld);
        return {1'b0, src, pin, run, pol, fld};
    endfunction

    task automatic wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic tick(int s, int k);
        for (int i = 0; i < k; i++) begin
            @(negedge clk);
            src_tick = 4'b0001 << s;
            @(negedge clk);
            src_tick = '0;
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), r);
            chk("R1 rdata", r, 0);
        end
        chk("R1 pulse_out", pulse_out, 0);
        chk("R1 comp_oe", comp_oe, 0);
        chk("R1 uf_strobe", uf_strobe, 0);
        chk("R1 irq_under", irq_under, 0);
        chk("R1 irq_edge", irq_edge, 0);
        chk("R11 comp_out after reset", comp_out, 1);

        // R2: write-through and read-back
        wr(2'd0, 8'h5A); rd(2'd0, r); chk("R2 prescaler", r, 8'h5A);
        wr(2'd1, 8'hC3); rd(2'd1, r); chk("R2 timer", r, 8'hC3);

        // Vector table: period, start level, edge interrupt per polarity
        for (int v = 0; v < 5; v++) begin
            vec_t t = VECS[v];
            int   p = (int'(t.n) + 1) * (int'(t.m) + 1);
            wr(2'd3, 8'h03);
            wr(2'd0, t.n);
            wr(2'd1, t.m);
            wr(2'd2, mk_mode(t.src, 1'b1, 1'b0, t.pol, 2'b01));
            chk("R6 start level", pulse_out, !t.pol);
            chk("R8 mode write sets edge flag", irq_edge, 1);
            chk("R11 comp_out", comp_out, t.pol);
            chk("R11 comp_oe", comp_oe, 1);
            wr(2'd2, mk_mode(t.src, 1'b1, 1'b1, t.pol, 2'b01));
            wr(2'd3, 8'h03);
            chk("R10 clear edge", irq_edge, 0);
            tick(t.src, p - 1);
            chk("R3 no toggle before period", pulse_out, !t.pol);
            chk("R9 no underflow yet", irq_under, 0);
            tick(t.src, 1);
            chk("R3 toggle at period", pulse_out, t.pol);
            chk("R9 underflow flag", irq_under, 1);
            chk("R7 wrong edge ignored", irq_edge, 0);
            tick(t.src, p);
            chk("R3 second toggle", pulse_out, !t.pol);
            chk("R7 chosen edge flagged", irq_edge, 1);
            rd(2'd0, r); chk("R3 prescaler reloaded", r, t.n);
            rd(2'd1, r); chk("R3 timer reloaded", r, t.m);
            wr(2'd2, mk_mode(t.src, 1'b1, 1'b0, t.pol, 2'b01));
        end

        // R5: stopped counters hold
        wr(2'd0, 8'd10); wr(2'd1, 8'd10);
        wr(2'd2, mk_mode(2'd2, 1'b0, 1'b0, 1'b0, 2'b01));
        chk("R11 comp_oe off", comp_oe, 0);
        tick(2, 5);
        rd(2'd0, r); chk("R5 hold when run=0", r, 10);
        wr(2'd3, 8'h03);
        wr(2'd2, mk_mode(2'd2, 1'b0, 1'b1, 1'b0, 2'b00));
        chk("R8 other mode field no edge flag", irq_edge, 0);
        tick(2, 5);
        rd(2'd0, r); chk("R5 hold when mode field not 01", r, 10);

        // R2 live count while running
        wr(2'd2, mk_mode(2'd2, 1'b0, 1'b1, 1'b0, 2'b01));
        tick(2, 3);
        rd(2'd0, r); chk("R2 live prescaler count", r, 7);

        // R4: unselected sources ignored
        tick(0, 5); tick(1, 5); tick(3, 5);
        rd(2'd0, r); chk("R4 unselected ticks ignored", r, 7);
        tick(2, 1);
        rd(2'd0, r); chk("R4 selected tick counts", r, 6);

        // R2 write mid-run
        wr(2'd1, 8'h20); rd(2'd1, r); chk("R2 timer write mid-run", r, 8'h20);

        // R9: strobe lasts one clock; R10 selective clear
        wr(2'd0, 8'd0); wr(2'd1, 8'd0);
        wr(2'd2, mk_mode(2'd0, 1'b0, 1'b1, 1'b0, 2'b01));
        @(negedge clk);
        src_tick = 4'b0001;
        #1 chk("R9 strobe during underflow", uf_strobe, 1);
        @(negedge clk);
        src_tick = '0;
        #1 chk("R9 strobe drops", uf_strobe, 0);
        chk("R10 both flags set", {irq_edge, irq_under}, 2'b11);
        wr(2'd3, 8'h01);
        chk("R10 under cleared", irq_under, 0);
        chk("R10 edge kept", irq_edge, 1);
        rd(2'd3, r); chk("R10 flag read", r, 8'h02);
        // R10 set wins over clear
        @(negedge clk);
        src_tick = 4'b0001; wr_en = 1'b1; addr = 2'd3; wdata = 8'h01;
        @(negedge clk);
        src_tick = '0; wr_en = 1'b0;
        chk("R10 set beats clear", irq_under, 1);

        finish_run();
    end
endmodule